// File: doc/BRIEF.md
# Walking-zero pattern generator

This block drives an N-bit bus (24 bits by default) with stimulus for glitch testing of a wide AND reduction. When started, it emits one word per clock with a valid strobe and a step index. It stops by itself and raises a one-cycle done flag. Two sequences are available. The walk sequence frames a single moving zero between all-zero and all-one words. The pairwise sequence takes every unordered pair of bit positions and moves the bus straight from a word whose only zero is at the first position to a word whose only zero is at the second. No word in between has both positions low, so the swap breaks before it makes.

The pattern bus comes from one register bank, so every bit of a word changes on the same clock edge. The generator adds no skew of its own to the transitions under test. The sequence is chosen at start and held for the whole run. A start request is acted on only when no run is in progress.

Top module: `walkzero_gen`

## Requirements
- R1: After reset the block is idle. The pattern is all zeros, and valid, done and the step index are all 0.
- R2: A start with mode 0 while idle produces, from the next cycle, a walk run of N+4 words: all zeros, all ones, then N words each with a single zero at bit k for k = 0 to N-1 in ascending order, then all ones, then all zeros. The step index of the word with its zero at bit k is k+2.
- R3: While a run is in progress, a new word appears every cycle with valid high. The step index starts at 0 and rises by one per word.
- R4: A start with mode 1 while idle produces a pairwise run. It covers every pair (i, j) with i < j, ordered by i, then by j, ascending. Each pair gives two words: the word whose only zero is at bit i, then the word whose only zero is at bit j. There are N*(N-1) words in total (552 for N = 24).
- R5: In a pairwise run, no two consecutive words have a zero at the same bit position.
- R6: The AND of all pattern bits is 1 only on the two all-ones words of a walk run (steps 1 and N+2). It is never 1 during a pairwise run.
- R7: In the cycle after the last word, done is high for exactly one cycle, valid is low and the pattern is all zeros.
- R8: A start during a run, including the cycle of the last word, is ignored, as is any change of the mode input. The run goes on unchanged and the block goes idle after done.
- R9: A start presented in the cycle where done is high is accepted. The new run's first word appears in the next cycle with step index 0.
- R10: Whenever valid is low, the pattern is all zeros and the step index is 0.
- R11: A reset during a run returns the block to the idle state of R1 at once, with no done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request to begin a run |
| mode_i | input | 1 | Sequence select at start: 0 walk, 1 pairwise |
| pattern_o | output | WIDTH | Stimulus word |
| valid_o | output | 1 | High while pattern_o carries a sequence word |
| done_o | output | 1 | One-cycle pulse after the final word |
| step_o | output | STEP_W | Index of the current word, counted from 0 |

## Verification
Two functions can fall in the same cycle: the done pulse of a finishing run and the acceptance of a new start. The bench holds start high in the cycle where done is seen, with the opposite mode selected. It then expects a first pairwise word with step 0 in the very next cycle. In a second case the bench raises start together with the final word of a run. There it expects done followed by an idle cycle, which shows that a request overlapping the last word is dropped, not queued.

// File: rtl/wz_pkg.sv
package wz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FINISH
    } seq_state_e;

    typedef enum logic {
        MODE_WALK = 1'b0,
        MODE_PAIR = 1'b1
    } run_mode_e;

    typedef enum logic [1:0] {
        WK_ZEROS,
        WK_ONES,
        WK_ONEZERO
    } word_kind_e;

    // Kind of word at walk step s for a bus of w bits
    function automatic word_kind_e walk_kind(input int unsigned s, input int unsigned w);
        if (s == 0 || s == w + 3)
            return WK_ZEROS;
        else if (s == 1 || s == w + 2)
            return WK_ONES;
        else
            return WK_ONEZERO;
    endfunction

endpackage

// File: rtl/wz_sequencer.sv
module wz_sequencer
    import wz_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic                     mode_i,
    output word_kind_e               nxt_kind_o,
    output logic [$clog2(WIDTH)-1:0] nxt_pos_o,
    output logic                     valid_o,
    output logic                     done_o,
    output logic [$clog2(WIDTH*(WIDTH-1))-1:0] step_o,
    output run_mode_e                mode_o
);

    localparam int POS_W      = $clog2(WIDTH);
    localparam int WALK_WORDS = WIDTH + 4;
    localparam int PAIR_WORDS = WIDTH * (WIDTH - 1);
    localparam int STEP_W     = $clog2(PAIR_WORDS);
    localparam logic [STEP_W-1:0] LAST_WALK = STEP_W'(WALK_WORDS - 1);
    localparam logic [STEP_W-1:0] LAST_PAIR = STEP_W'(PAIR_WORDS - 1);
    localparam logic [POS_W-1:0]  TOP_POS   = POS_W'(WIDTH - 1);

    seq_state_e          state_q, state_d;
    run_mode_e           mode_q, mode_d;
    logic [STEP_W-1:0]   step_q, step_d;
    logic [POS_W-1:0]    lo_q, lo_d, hi_q, hi_d;
    logic                half_q, half_d;
    logic                done_q, done_d;
    word_kind_e          kind_d;
    logic [POS_W-1:0]    pos_d;
    logic                accept, last_word;

    assign accept    = start_i && (state_q != ST_RUN);
    assign last_word = (mode_q == MODE_WALK) ? (step_q == LAST_WALK) : (step_q == LAST_PAIR);

    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        step_d  = '0;
        lo_d    = lo_q;
        hi_d    = hi_q;
        half_d  = half_q;
        done_d  = 1'b0;
        kind_d  = WK_ZEROS;
        pos_d   = '0;
        if (state_q == ST_RUN) begin
            if (last_word) begin
                state_d = ST_FINISH;
                done_d  = 1'b1;
            end else begin
                step_d = step_q + STEP_W'(1);
                if (mode_q == MODE_WALK) begin
                    kind_d = walk_kind(32'(step_d), WIDTH);
                    pos_d  = POS_W'(32'(step_d) - 2);
                end else if (!half_q) begin
                    half_d = 1'b1;
                    kind_d = WK_ONEZERO;
                    pos_d  = hi_q;
                end else begin
                    half_d = 1'b0;
                    if (hi_q == TOP_POS) begin
                        lo_d = lo_q + POS_W'(1);
                        hi_d = lo_q + POS_W'(2);
                    end else begin
                        hi_d = hi_q + POS_W'(1);
                    end
                    kind_d = WK_ONEZERO;
                    pos_d  = lo_d;
                end
            end
        end else if (accept) begin
            state_d = ST_RUN;
            mode_d  = run_mode_e'(mode_i);
            lo_d    = '0;
            hi_d    = POS_W'(1);
            half_d  = 1'b0;
            kind_d  = mode_i ? WK_ONEZERO : WK_ZEROS;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_WALK;
            step_q  <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
            half_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode_d;
            step_q  <= step_d;
            lo_q    <= lo_d;
            hi_q    <= hi_d;
            half_q  <= half_d;
            done_q  <= done_d;
        end
    end

    assign nxt_kind_o = kind_d;
    assign nxt_pos_o  = pos_d;
    assign valid_o    = (state_q == ST_RUN);
    assign done_o     = done_q;
    assign step_o     = step_q;
    assign mode_o     = mode_q;

    // R7
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R7
    valid_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(valid_o && done_o));

    // R3
    step_incr_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o)) |-> (step_o == $past(step_o) + STEP_W'(1)));

    // R8
    run_mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o)) |-> $stable(mode_o));

endmodule

// File: rtl/wz_word_build.sv
module wz_word_build
    import wz_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  word_kind_e               kind_i,
    input  logic [$clog2(WIDTH)-1:0] pos_i,
    output logic [WIDTH-1:0]         word_o
);

    localparam int POS_W = $clog2(WIDTH);

    logic [WIDTH-1:0] word_d, word_q;

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign word_d[b] = (kind_i == WK_ONES) ||
                           ((kind_i == WK_ONEZERO) && (pos_i != POS_W'(b)));
    end

    always_ff @(posedge clk) begin
        if (rst) word_q <= '0;
        else     word_q <= word_d;
    end

    assign word_o = word_q;

endmodule

// File: rtl/walkzero_gen.sv
module walkzero_gen
    import wz_pkg::*;
#(
    parameter int WIDTH = 24
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                start_i,
    input  logic                                mode_i,
    output logic [WIDTH-1:0]                    pattern_o,
    output logic                                valid_o,
    output logic                                done_o,
    output logic [$clog2(WIDTH*(WIDTH-1))-1:0]  step_o
);

    localparam int POS_W  = $clog2(WIDTH);
    localparam int STEP_W = $clog2(WIDTH * (WIDTH - 1));

    word_kind_e        nxt_kind;
    logic [POS_W-1:0]  nxt_pos;
    run_mode_e         run_mode;

    wz_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .mode_i     (mode_i),
        .nxt_kind_o (nxt_kind),
        .nxt_pos_o  (nxt_pos),
        .valid_o    (valid_o),
        .done_o     (done_o),
        .step_o     (step_o),
        .mode_o     (run_mode)
    );

    wz_word_build #(.WIDTH(WIDTH)) u_word (
        .clk    (clk),
        .rst    (rst),
        .kind_i (nxt_kind),
        .pos_i  (nxt_pos),
        .word_o (pattern_o)
    );

    // R5
    no_shared_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o) && run_mode == MODE_PAIR)
            |-> ((~pattern_o & ~$past(pattern_o)) == '0));

    // R4
    pair_single_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && run_mode == MODE_PAIR) |-> ($countones(~pattern_o) == 1));

    // R6
    and_high_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_o && (&pattern_o)) |->
            (run_mode == MODE_WALK &&
             (step_o == STEP_W'(1) || step_o == STEP_W'(WIDTH + 2))));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (pattern_o == '0 && step_o == '0));

endmodule

// File: tb/walkzero_gen_bench.sv
`timescale 1ns/1ps
module walkzero_gen_bench;

    localparam int W       = 24;
    localparam int STEP_W  = $clog2(W * (W - 1));
    localparam int N_WALK  = W + 4;
    localparam int N_PAIR  = W * (W - 1);
    localparam realtime HALF = 2.0;

    logic              clk = 1'b0;
    logic              rst, start, mode;
    logic [W-1:0]      pattern;
    logic              valid, done;
    logic [STEP_W-1:0] step;

    int n_cmp = 0;
    int n_bad = 0;

    always #(HALF) clk = ~clk;

    walkzero_gen #(.WIDTH(W)) u_walkzero_gen (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start),
        .mode_i    (mode),
        .pattern_o (pattern),
        .valid_o   (valid),
        .done_o    (done),
        .step_o    (step)
    );

    function automatic logic [W-1:0] one_zero(input int p);
        logic [W-1:0] v = '1;
        v[p] = 1'b0;
        return v;
    endfunction

    function automatic logic [W-1:0] walk_word(input int k);
        if (k == 0 || k == W + 3) return '0;
        if (k == 1 || k == W + 2) return '1;
        return one_zero(k - 2);
    endfunction

    task automatic chk_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_idle(input string req);
        chk_vec(req, pattern, '0);
        chk_int(req, int'(valid), 0);
        chk_int(req, int'(step), 0);
    endtask

    task automatic pulse_start(input logic m);
        start = 1'b1;
        mode  = m;
        @(negedge clk);
        start = 1'b0;
    endtask

    // R1
    task automatic t_reset();
        chk_idle("R1 in reset");
        chk_int("R1 done in reset", int'(done), 0);
        rst = 1'b0;
        @(negedge clk);
        chk_idle("R1 after reset");
        chk_int("R1 done after reset", int'(done), 0);
    endtask

    // R2 R3 R6 R7, and R8 when poke is set
    task automatic t_walk(input bit poke);
        pulse_start(1'b0);
        for (int k = 0; k < N_WALK; k++) begin
            if (poke && (k == 5 || k == N_WALK - 1)) begin
                start = 1'b1;
                mode  = 1'b1;
            end else begin
                start = 1'b0;
                mode  = 1'b0;
            end
            chk_vec(poke ? "R8 walk word" : "R2 walk word", pattern, walk_word(k));
            chk_int("R3 valid", int'(valid), 1);
            chk_int("R3 step", int'(step), k);
            chk_int("R6 and", int'(&pattern), (k == 1 || k == W + 2) ? 1 : 0);
            @(negedge clk);
        end
        start = 1'b0;
        chk_int("R7 done", int'(done), 1);
        chk_int("R7 valid low", int'(valid), 0);
        chk_vec("R7 pattern zero", pattern, '0);
        @(negedge clk);
        chk_int("R7 done single", int'(done), 0);
        chk_idle(poke ? "R8 idle after ignored start" : "R10 idle");
    endtask

    // R4 R5 R6
    task automatic t_pair();
        int n = 0;
        logic [W-1:0] prev = '1;
        pulse_start(1'b1);
        for (int i = 0; i < W; i++) begin
            for (int j = i + 1; j < W; j++) begin
                for (int h = 0; h < 2; h++) begin
                    chk_vec("R4 pair word", pattern, one_zero(h == 0 ? i : j));
                    chk_int("R4 step", int'(step), n);
                    if (n > 0) chk_vec("R5 no shared zero", ~pattern & ~prev, '0);
                    chk_int("R6 and low", int'(&pattern), 0);
                    prev = pattern;
                    n++;
                    @(negedge clk);
                end
            end
        end
        chk_int("R4 word count", n, N_PAIR);
        chk_int("R7 pair done", int'(done), 1);
        chk_int("R7 pair valid low", int'(valid), 0);
        @(negedge clk);
    endtask

    // R9 then R11
    task automatic t_restart_and_reset();
        pulse_start(1'b0);
        repeat (N_WALK) @(negedge clk);
        chk_int("R9 done seen", int'(done), 1);
        pulse_start(1'b1);
        chk_int("R9 valid", int'(valid), 1);
        chk_int("R9 step", int'(step), 0);
        chk_vec("R9 first pair word", pattern, one_zero(0));
        @(negedge clk);
        chk_vec("R9 second pair word", pattern, one_zero(1));
        repeat (8) @(negedge clk);
        chk_int("R11 running before reset", int'(valid), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk_idle("R11 idle after reset");
        chk_int("R11 no done", int'(done), 0);
        @(negedge clk);
        chk_idle("R11 stays idle");
        chk_int("R11 no done later", int'(done), 0);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_bad++;
        $display("FAIL watchdog expired R3");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst   = 1'b1;
        start = 1'b0;
        mode  = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_walk(1'b0);
        t_pair();
        t_walk(1'b1);
        t_restart_and_reset();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule